// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Age-Counter Replacement

This block translates virtual addresses into physical addresses through a small, fully associative table of page mappings. Each request carries a virtual address and a read/write flag. The address is split into a page number and a byte offset. The page number is compared against every stored mapping at once, and the registered response returns the physical address on the cycle after the request. Each stored mapping holds these fields:

- a valid bit
- a dirty bit
- two permission bits
- a small age counter that measures how long ago the entry was last used

When no entry matches, the block installs a new mapping. It takes the frame at the head of an internal queue of free physical frames, which is filled through a push port. The victim slot is chosen by age. A request that the entry's permissions forbid produces a protection fault instead of an address. A miss that finds the queue empty produces a page fault and leaves every entry untouched. A flush input invalidates the whole table in a single cycle, for use on a context switch.

Top module: `tlb_lru`

## Requirements
- R1: The low `OFF_W` bits of the virtual address (log2 of the page size) are copied unchanged into the low bits of the physical address. The upper bits of the physical address are the stored physical page number, which may be narrower than the virtual page number.
- R2: A request accepted at a clock edge produces `rsp_valid` high for exactly the following cycle. If any valid entry holds the request's page number, `rsp_hit` is 1 and the translation comes from that entry. When no request is accepted, `rsp_valid`, `rsp_hit` and both fault outputs are 0. All outputs are 0 after reset.
- R3: Every access that touches an entry (a hit, or a new install) sets that entry's age to 0. The same access increments the age of every other valid entry, saturating at 2^`AGE_W`-1. Page faults and flushes change no age.
- R4: A miss with a non-empty frame queue removes the frame at the head of the queue. It installs that frame, with the frame's permission bits, in a slot marked valid, and reports `rsp_hit`=0. Frames are consumed in the order they were pushed.
- R5: The slot for a new install is the lowest-indexed invalid slot, if there is one. Otherwise it is the slot with the largest age, with ties going to the lowest index.
- R6: A permitted write sets the entry's dirty bit; this covers a write miss, which installs the entry already dirty. On a successful access, `rsp_dirty` shows the entry's dirty bit after the access.
- R7: `flush` clears every valid bit at the next edge. It takes priority over a request in the same cycle, and that request is dropped with no response.
- R8: Permission bit 0 allows reads and bit 1 allows writes. A forbidden access raises `rsp_fault_prot`, forces `rsp_paddr` and `rsp_dirty` to 0, and leaves the dirty bit unchanged. It still counts as a touch for ages, and a forbidden install still stores the entry.
- R9: A miss while the frame queue is empty raises `rsp_fault_page` with `rsp_hit`=0 and `rsp_paddr`=0. It leaves every entry and the queue unchanged.
- R10: The frame queue holds `FRAMES` entries. A push while the queue is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | VA_W | Virtual address |
| flush | input | 1 | Invalidate all entries |
| frame_push | input | 1 | Append a free frame to the queue |
| frame_ppn | input | PPN_W | Physical page number of the pushed frame |
| frame_perm | input | 2 | Permissions of the pushed frame (bit 0 read, bit 1 write) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request matched a stored entry |
| rsp_paddr | output | PPN_W+OFF_W | Physical address, 0 on any fault |
| rsp_dirty | output | 1 | Dirty bit of the entry after a successful access |
| rsp_fault_prot | output | 1 | Access forbidden by permissions |
| rsp_fault_page | output | 1 | Miss with no free frame |

## Verification
The hardest state to reach is one where every slot is valid and several ages have saturated together. Only there do the tie-break rule and the saturation limit decide the victim. The bench gets there by filling all four slots and then hitting one entry repeatedly until the others sit at the ceiling. It then forces a miss and probes which page number still hits. A long sweep over all sixteen page numbers follows, with both access types, pushes that are sometimes withheld and rotating permission codes. Against a reference model kept in the bench, this sweep reaches full, empty and overflowing queue states and mixes hits, installs and faults in many orders.

// File: rtl/tlb_lru_pkg.sv
package tlb_lru_pkg;

    localparam int PERM_W     = 2;
    localparam int PERM_RD    = 0;
    localparam int PERM_WR    = 1;

    typedef logic [PERM_W-1:0] perm_t;

    function automatic logic perm_allows(input perm_t p, input logic is_write);
        return is_write ? p[PERM_WR] : p[PERM_RD];
    endfunction

endpackage

// File: rtl/tlb_frame_fifo.sv
module tlb_frame_fifo
    import tlb_lru_pkg::*;
#(
    parameter int PPN_W = 3,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PPN_W-1:0] push_ppn,
    input  perm_t            push_perm,
    input  logic             pop,
    output logic [PPN_W-1:0] head_ppn,
    output perm_t            head_perm,
    output logic             empty
);

    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int SLOT_W = PPN_W + PERM_W;

    typedef struct packed {
        logic [DEPTH-1:0][SLOT_W-1:0] slot;
        logic [PTR_W-1:0]             rd_ptr;
        logic [PTR_W-1:0]             wr_ptr;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic full;
    logic push_ok;
    logic pop_ok;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign {head_ppn, head_perm} = st_q.slot[st_q.rd_ptr];

    always_comb begin
        st_d    = st_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (pop_ok) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        if (push_ok) begin
            st_d.slot[st_q.wr_ptr] = {push_ppn, push_perm};
            st_d.wr_ptr            = ptr_next(st_q.wr_ptr);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlb_cam_search.sv
module tlb_cam_search #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tag,
    input  logic [VPN_W-1:0]              look,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);

    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == look);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int ENTRIES = 4,
    parameter int AGE_W   = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][AGE_W-1:0] age,
    output logic [IDX_W-1:0]              victim
);

    logic             free_seen;
    logic [IDX_W-1:0] free_idx;
    logic [AGE_W-1:0] oldest;
    logic [IDX_W-1:0] oldest_idx;

    always_comb begin
        free_seen = 1'b0;
        free_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld[i] && !free_seen) begin
                free_seen = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        oldest     = age[0];
        oldest_idx = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (age[i] > oldest) begin
                oldest     = age[i];
                oldest_idx = IDX_W'(i);
            end
        end
    end

    assign victim = free_seen ? free_idx : oldest_idx;

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru
    import tlb_lru_pkg::*;
#(
    parameter int VA_W       = 10,
    parameter int PAGE_BYTES = 64,
    parameter int PPN_W      = 3,
    parameter int ENTRIES    = 4,
    parameter int AGE_W      = 2,
    parameter int FRAMES     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PA_W      = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             flush,
    input  logic             frame_push,
    input  logic [PPN_W-1:0] frame_ppn,
    input  logic [1:0]       frame_perm,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_dirty,
    output logic             rsp_fault_prot,
    output logic             rsp_fault_page
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             drt;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
        logic [ENTRIES-1:0][AGE_W-1:0]  age;
        logic                           r_valid;
        logic                           r_hit;
        logic [PA_W-1:0]                r_paddr;
        logic                           r_dirty;
        logic                           r_prot;
        logic                           r_page;
    } tlb_st_t;

    tlb_st_t st_d, st_q;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             cam_hit;
    logic [IDX_W-1:0] cam_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [PPN_W-1:0] q_ppn;
    perm_t            q_perm;
    logic             q_empty;
    logic             q_pop;
    logic             touch;
    logic [IDX_W-1:0] use_idx;
    logic             allowed;
    logic [ENTRIES-1:0] vld_now;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];
    assign vld_now = st_q.vld;

    tlb_cam_search #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W)
    ) i_search (
        .vld     (st_q.vld),
        .tag     (st_q.vpn),
        .look    (req_vpn),
        .hit     (cam_hit),
        .hit_idx (cam_idx)
    );

    tlb_victim_pick #(
        .ENTRIES (ENTRIES),
        .AGE_W   (AGE_W)
    ) i_victim (
        .vld     (st_q.vld),
        .age     (st_q.age),
        .victim  (victim_idx)
    );

    tlb_frame_fifo #(
        .PPN_W   (PPN_W),
        .DEPTH   (FRAMES)
    ) i_frames (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (frame_push),
        .push_ppn  (frame_ppn),
        .push_perm (frame_perm),
        .pop       (q_pop),
        .head_ppn  (q_ppn),
        .head_perm (q_perm),
        .empty     (q_empty)
    );

    always_comb begin
        st_d         = st_q;
        st_d.r_valid = 1'b0;
        st_d.r_hit   = 1'b0;
        st_d.r_paddr = '0;
        st_d.r_dirty = 1'b0;
        st_d.r_prot  = 1'b0;
        st_d.r_page  = 1'b0;
        q_pop        = 1'b0;
        touch        = 1'b0;
        use_idx      = '0;
        allowed      = 1'b0;

        if (flush) begin
            st_d.vld = '0;
        end else if (req_valid) begin
            st_d.r_valid = 1'b1;
            if (cam_hit) begin
                touch        = 1'b1;
                use_idx      = cam_idx;
                st_d.r_hit   = 1'b1;
                allowed      = perm_allows(st_q.perm[cam_idx], req_write);
                if (allowed) begin
                    if (req_write) begin
                        st_d.drt[cam_idx] = 1'b1;
                    end
                    st_d.r_paddr = {st_q.ppn[cam_idx], req_off};
                    st_d.r_dirty = st_q.drt[cam_idx] | req_write;
                end else begin
                    st_d.r_prot = 1'b1;
                end
            end else if (q_empty) begin
                st_d.r_page = 1'b1;
            end else begin
                touch                 = 1'b1;
                use_idx               = victim_idx;
                q_pop                 = 1'b1;
                allowed               = perm_allows(q_perm, req_write);
                st_d.vld[victim_idx]  = 1'b1;
                st_d.vpn[victim_idx]  = req_vpn;
                st_d.ppn[victim_idx]  = q_ppn;
                st_d.perm[victim_idx] = q_perm;
                st_d.drt[victim_idx]  = req_write & allowed;
                if (allowed) begin
                    st_d.r_paddr = {q_ppn, req_off};
                    st_d.r_dirty = req_write;
                end else begin
                    st_d.r_prot = 1'b1;
                end
            end

            if (touch) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == use_idx) begin
                        st_d.age[i] = '0;
                    end else if (st_q.vld[i] && (st_q.age[i] != '1)) begin
                        st_d.age[i] = st_q.age[i] + AGE_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid      = st_q.r_valid;
    assign rsp_hit        = st_q.r_hit;
    assign rsp_paddr      = st_q.r_paddr;
    assign rsp_dirty      = st_q.r_dirty;
    assign rsp_fault_prot = st_q.r_prot;
    assign rsp_fault_page = st_q.r_page;

endmodule

// File: rtl/tlb_lru_chk.sv
module tlb_lru_chk #(
    parameter int VA_W    = 10,
    parameter int OFF_W   = 6,
    parameter int PA_W    = 9,
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               flush,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               rsp_dirty,
    input logic               rsp_fault_prot,
    input logic               rsp_fault_page,
    input logic [ENTRIES-1:0] vld_now
);

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault_prot && !rsp_fault_page)
        |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flush) |=> rsp_valid);

    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !flush) |=> !rsp_valid);

    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_fault_prot && !rsp_fault_page);

    p_write_marks_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !flush)
        |=> (rsp_fault_prot || rsp_fault_page || rsp_dirty));

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_now == '0) && !rsp_valid);

    p_prot_blocks_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_prot |-> (rsp_paddr == '0) && !rsp_dirty && !rsp_fault_page);

    p_page_fault_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_page |-> !rsp_hit && (rsp_paddr == '0));

    p_page_fault_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_page |-> $stable(vld_now));

endmodule

bind tlb_lru tlb_lru_chk #(
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .PA_W    (PA_W),
    .ENTRIES (ENTRIES)
) i_tlb_lru_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_vaddr      (req_vaddr),
    .flush          (flush),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_paddr      (rsp_paddr),
    .rsp_dirty      (rsp_dirty),
    .rsp_fault_prot (rsp_fault_prot),
    .rsp_fault_page (rsp_fault_page),
    .vld_now        (vld_now)
);

// File: tb/test_tlb_lru.sv
module test_tlb_lru;

    localparam int VA_W   = 10;
    localparam int OFF_W  = 6;
    localparam int PPN_W  = 3;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int NENT   = 4;
    localparam int AGEMAX = 3;
    localparam int NFRM   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             flush = 1'b0;
    logic             frame_push = 1'b0;
    logic [PPN_W-1:0] frame_ppn = '0;
    logic [1:0]       frame_perm = '0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [PA_W-1:0]  rsp_paddr;
    logic             rsp_dirty;
    logic             rsp_fault_prot;
    logic             rsp_fault_page;

    always #2 clk = ~clk;

    tlb_lru i_tlb_lru (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_vaddr      (req_vaddr),
        .flush          (flush),
        .frame_push     (frame_push),
        .frame_ppn      (frame_ppn),
        .frame_perm     (frame_perm),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_paddr      (rsp_paddr),
        .rsp_dirty      (rsp_dirty),
        .rsp_fault_prot (rsp_fault_prot),
        .rsp_fault_page (rsp_fault_page)
    );

    int n_cmp = 0;
    int n_bad = 0;

    int m_vld [NENT];
    int m_vpn [NENT];
    int m_ppn [NENT];
    int m_perm[NENT];
    int m_drt [NENT];
    int m_age [NENT];
    int fq_ppn [NFRM];
    int fq_perm[NFRM];
    int fq_head = 0;
    int fq_cnt  = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_frame(input int ppn, input int perm);
        frame_push = 1'b1;
        frame_ppn  = PPN_W'(ppn);
        frame_perm = 2'(perm);
        @(posedge clk);
        @(negedge clk);
        frame_push = 1'b0;
        if (fq_cnt < NFRM) begin
            fq_ppn [(fq_head + fq_cnt) % NFRM] = ppn;
            fq_perm[(fq_head + fq_cnt) % NFRM] = perm;
            fq_cnt++;
        end
    endtask

    task automatic access(input int va, input int wr, input string tag);
        int vpn, off, h, use_i, ok, e_hit, e_pa, e_d, e_fp, e_fg, best;
        vpn = va >> OFF_W;
        off = va % (1 << OFF_W);
        h = -1; use_i = -1; ok = 0;
        e_hit = 0; e_pa = 0; e_d = 0; e_fp = 0; e_fg = 0;
        for (int i = 0; i < NENT; i++) if (m_vld[i] != 0 && m_vpn[i] == vpn) h = i;
        if (h >= 0) begin
            e_hit = 1;
            use_i = h;
            ok = wr != 0 ? (m_perm[h] >> 1) & 1 : m_perm[h] & 1;
            if (ok != 0) begin
                if (wr != 0) m_drt[h] = 1;
                e_d  = m_drt[h];
                e_pa = (m_ppn[h] << OFF_W) | off;
            end else e_fp = 1;
        end else if (fq_cnt == 0) begin
            e_fg = 1;
        end else begin
            for (int i = NENT - 1; i >= 0; i--) if (m_vld[i] == 0) use_i = i;
            if (use_i < 0) begin
                use_i = 0; best = m_age[0];
                for (int i = 1; i < NENT; i++) if (m_age[i] > best) begin best = m_age[i]; use_i = i; end
            end
            m_vld[use_i]  = 1;
            m_vpn[use_i]  = vpn;
            m_ppn[use_i]  = fq_ppn[fq_head];
            m_perm[use_i] = fq_perm[fq_head];
            fq_head = (fq_head + 1) % NFRM;
            fq_cnt--;
            ok = wr != 0 ? (m_perm[use_i] >> 1) & 1 : m_perm[use_i] & 1;
            m_drt[use_i] = (wr != 0 && ok != 0) ? 1 : 0;
            if (ok != 0) begin
                e_d  = wr;
                e_pa = (m_ppn[use_i] << OFF_W) | off;
            end else e_fp = 1;
        end
        if (use_i >= 0) begin
            for (int i = 0; i < NENT; i++) begin
                if (i == use_i) m_age[i] = 0;
                else if (m_vld[i] != 0 && m_age[i] < AGEMAX) m_age[i]++;
            end
        end

        req_valid = 1'b1;
        req_write = wr[0];
        req_vaddr = VA_W'(va);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "rsp_valid", int'(rsp_valid), 1);
        chk(tag, "rsp_hit", int'(rsp_hit), e_hit);
        chk(tag, "rsp_paddr", int'(rsp_paddr), e_pa);
        chk(tag, "rsp_dirty", int'(rsp_dirty), e_d);
        chk(tag, "rsp_fault_prot", int'(rsp_fault_prot), e_fp);
        chk(tag, "rsp_fault_page", int'(rsp_fault_page), e_fg);
        if (e_fp == 0 && e_fg == 0)
            chk("R1", "offset", int'(rsp_paddr) % (1 << OFF_W), off);
    endtask

    task automatic do_flush(input int va);
        flush     = 1'b1;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_vaddr = VA_W'(va);
        @(posedge clk);
        @(negedge clk);
        flush     = 1'b0;
        req_valid = 1'b0;
        chk("R7", "rsp_valid after flush", int'(rsp_valid), 0);
        for (int i = 0; i < NENT; i++) m_vld[i] = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k;
        for (int i = 0; i < NENT; i++) begin
            m_vld[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_perm[i] = 0; m_drt[i] = 0; m_age[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk("R2", "reset rsp_valid", int'(rsp_valid), 0);
        chk("R2", "reset rsp_hit", int'(rsp_hit), 0);
        chk("R2", "reset rsp_paddr", int'(rsp_paddr), 0);

        // R9 miss with empty queue, then prove nothing was installed
        access(2 << OFF_W | 5, 0, "R9");
        push_frame(3, 3);
        access(2 << OFF_W | 6, 0, "R9");

        // R10 overflow: nine pushes into an eight-deep queue
        do_flush(0);
        for (int i = 0; i < 9; i++) push_frame(i % NFRM, 3);
        for (int i = 0; i < 9; i++) access((i + 4) << OFF_W | i, 0, "R10");

        // R4 queue order
        do_flush(0);
        push_frame(5, 3);
        push_frame(2, 3);
        access(7 << OFF_W | 1, 0, "R4");
        access(8 << OFF_W | 2, 0, "R4");

        // R3 and R5: fill, saturate ages, tie broken to lowest index
        do_flush(0);
        for (int i = 0; i < 4; i++) push_frame(i + 1, 3);
        for (int i = 1; i <= 4; i++) access(i << OFF_W, 0, "R5");
        for (int i = 0; i < 3; i++) access(4 << OFF_W | 9, 0, "R3");
        push_frame(6, 3);
        access(5 << OFF_W, 0, "R5");
        access(2 << OFF_W | 3, 0, "R3");
        push_frame(7, 3);
        access(1 << OFF_W | 4, 0, "R5");
        access(3 << OFF_W | 8, 0, "R3");

        // R8 and R6 permissions and dirty
        do_flush(0);
        push_frame(6, 1);
        access(9 << OFF_W | 11, 1, "R8");
        access(9 << OFF_W | 12, 0, "R8");
        access(9 << OFF_W | 13, 1, "R8");
        push_frame(4, 2);
        access(10 << OFF_W | 1, 0, "R8");
        access(10 << OFF_W | 2, 1, "R6");
        access(10 << OFF_W | 3, 1, "R6");
        push_frame(2, 3);
        access(11 << OFF_W | 4, 1, "R6");
        access(11 << OFF_W | 5, 0, "R6");

        // R7 flush drops entries
        do_flush(11 << OFF_W);
        push_frame(1, 3);
        access(11 << OFF_W | 6, 0, "R7");

        // Sweep over page numbers, access types, permissions and queue levels
        k = 0;
        for (int r = 0; r < 8; r++) begin
            for (int v = 0; v < 16; v++) begin
                for (int w = 0; w < 2; w++) begin
                    if (((r * 32 + v * 2 + w) % 3) != 0) begin
                        push_frame(k % NFRM, (k * 3 + r) % 4);
                        k++;
                    end
                    access((((v * 7 + r * 3) % 16) << OFF_W) | ((v * 5 + w + r * 11) % 64), w, "R5");
                end
            end
            if (r % 3 == 2) do_flush(0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule